// File: doc/BRIEF.md
# Thermal Sensor Kelvin Converter

This block turns raw thermal sensor readings into an absolute temperature. Three calibration readings are written once through a load strobe and kept. A fourth, live reading arrives as a 23-bit two's-complement value and can be rewritten whenever the sensor reports.

A start pulse takes a snapshot of all four values. The block forms a scaled difference ratio and applies a correction factor with integer divisions. It then adds a small centring offset and reports the result in kelvin, with a derived celsius value.

Both divisions run on one shared signed restoring divider, which produces one quotient bit per clock. A one-cycle done pulse marks each finished result. A separate flag shows whether that result lies outside a fixed kelvin window. If the two calibration values that form the divisor are equal, no division is attempted and an error is reported instead.

Top module: `temp_kelvin_calc`

## Requirements
- R1: While reset is held and after it is released, busy, done and div_err are 0, kelvin is 0, celsius is -273 and out_of_range is 1.
- R2: With calibration values A (cal_a), B (cal_b) and C (cal_c), and the live value L, the result is kelvin = ((25123 × (L − B)) / (C − A)) / 100 + 8. Each division is an integer division that truncates toward zero, and the two are done in that order.
- R3: live_raw is treated as a 23-bit two's-complement number and sign-extended before any arithmetic, so 23'h7FFFFF counts as −1.
- R4: For a non-zero divisor, busy is high from the edge that samples start. done is a single-cycle pulse that rises 2·W edges after that edge (96 with defaults), and busy falls on that same edge.
- R5: A start pulse while busy is high is ignored. It starts no new computation, and no extra done pulse follows.
- R6: The operands are captured on the edge that samples start. Writes to the live value during a computation do not change that computation's result.
- R7: When cal_c equals cal_a, done and div_err pulse together on the edge that samples start. kelvin, celsius and out_of_range keep their previous values.
- R8: out_of_range is 1 exactly when kelvin is below 263 or above 410. The values 263 and 410 count as in range.
- R9: celsius always equals kelvin − 273.
- R10: kelvin changes only on an edge where done is raised.
- R11: Calibration values change only when cal_load is high. Without cal_load, values on the calibration inputs have no effect on later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_load | input | 1 | Stores cal_a, cal_b and cal_c |
| cal_a | input | CAL_W | Calibration value subtracted in the divisor |
| cal_b | input | CAL_W | Calibration value subtracted from the live reading |
| cal_c | input | CAL_W | Calibration value that forms the divisor with cal_a |
| live_we | input | 1 | Stores live_raw |
| live_raw | input | RAW_W | Live sensor reading, two's complement |
| start | input | 1 | Starts a conversion when the block is idle |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| div_err | output | 1 | Pulses with done when the divisor is zero |
| out_of_range | output | 1 | Current kelvin lies outside 263..410 |
| kelvin | output | W | Signed result in kelvin |
| celsius | output | W | Signed result in degrees celsius |

## Verification
A normal conversion finishes exactly 96 edges after the edge that samples start. A zero divisor finishes on that same edge. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the start edge until done and requires the exact count, then checks kelvin, celsius, the range flag and the error flag in that cycle. On the next falling edge it checks that done has dropped.

For the ignored-start and mid-run live-write cases, the stimulus is applied at fixed counts within the busy window. The bench then watches the outputs for more than one full conversion time to confirm no second completion appears.

// File: rtl/temp_kelvin_calc.sv
module temp_kelvin_calc #(
  parameter int RAW_W    = 23,
  parameter int CAL_W    = 32,
  parameter int W        = 48,
  parameter int SLOPE    = 259,
  parameter int CORR_NUM = 97,
  parameter int CORR_DEN = 100,
  parameter int OFFSET   = 8,
  parameter int T_MIN    = 263,
  parameter int T_MAX    = 410,
  parameter int C_SHIFT  = 273
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cal_load,
  input  logic signed [CAL_W-1:0] cal_a,
  input  logic signed [CAL_W-1:0] cal_b,
  input  logic signed [CAL_W-1:0] cal_c,
  input  logic                    live_we,
  input  logic [RAW_W-1:0]        live_raw,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic                    div_err,
  output logic                    out_of_range,
  output logic signed [W-1:0]     kelvin,
  output logic signed [W-1:0]     celsius
);
  localparam int CW = $clog2(W + 1);
  localparam logic signed [W-1:0] GAIN   = W'(CORR_NUM * SLOPE);
  localparam logic [W-1:0]        DEN2   = W'(CORR_DEN);
  localparam logic signed [W-1:0] OFS    = W'(OFFSET);
  localparam logic signed [W-1:0] LO     = W'(T_MIN);
  localparam logic signed [W-1:0] HI     = W'(T_MAX);
  localparam logic signed [W-1:0] CSHIFT = W'(C_SHIFT);

  typedef enum logic [1:0] {S_IDLE, S_DIV1, S_DIV2} st_t;
  st_t st;

  logic signed [CAL_W-1:0] ca, cb, cc;
  logic [RAW_W-1:0]        lv;
  logic [W-1:0]            rem, quo, dvs;
  logic [CW-1:0]           cnt;
  logic                    neg;

  logic signed [W-1:0] lv_x, cb_x, ca_x, cc_x, num, den;
  assign lv_x = {{(W-RAW_W){lv[RAW_W-1]}}, lv};
  assign cb_x = {{(W-CAL_W){cb[CAL_W-1]}}, cb};
  assign ca_x = {{(W-CAL_W){ca[CAL_W-1]}}, ca};
  assign cc_x = {{(W-CAL_W){cc[CAL_W-1]}}, cc};
  assign num  = (lv_x - cb_x) * GAIN;
  assign den  = cc_x - ca_x;

  logic [W-1:0] num_mag, den_mag;
  assign num_mag = num[W-1] ? W'(-num) : W'(num);
  assign den_mag = den[W-1] ? W'(-den) : W'(den);

  logic [W:0]   shifted, trial;
  logic         take;
  logic [W-1:0] next_rem, next_quo;
  assign shifted  = {rem, quo[W-1]};
  assign trial    = shifted - {1'b0, dvs};
  assign take     = !trial[W];
  assign next_rem = take ? trial[W-1:0] : shifted[W-1:0];
  assign next_quo = {quo[W-2:0], take};

  logic signed [W-1:0] q_fin, k_new;
  assign q_fin = neg ? -$signed(next_quo) : $signed(next_quo);
  assign k_new = q_fin + OFS;

  assign busy    = (st != S_IDLE);
  assign celsius = kelvin - CSHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      ca           <= '0;
      cb           <= '0;
      cc           <= '0;
      lv           <= '0;
      rem          <= '0;
      quo          <= '0;
      dvs          <= '0;
      cnt          <= '0;
      neg          <= 1'b0;
      done         <= 1'b0;
      div_err      <= 1'b0;
      kelvin       <= '0;
      out_of_range <= 1'b1;
    end else begin
      done    <= 1'b0;
      div_err <= 1'b0;
      if (cal_load) begin
        ca <= cal_a;
        cb <= cal_b;
        cc <= cal_c;
      end
      if (live_we) lv <= live_raw;
      case (st)
        S_IDLE: if (start) begin
          if (den == '0) begin
            done    <= 1'b1;
            div_err <= 1'b1;
          end else begin
            rem <= '0;
            quo <= num_mag;
            dvs <= den_mag;
            neg <= num[W-1] ^ den[W-1];
            cnt <= CW'(W);
            st  <= S_DIV1;
          end
        end
        S_DIV1: begin
          quo <= next_quo;
          if (cnt == CW'(1)) begin
            rem <= '0;
            dvs <= DEN2;
            cnt <= CW'(W);
            st  <= S_DIV2;
          end else begin
            rem <= next_rem;
            cnt <= cnt - CW'(1);
          end
        end
        S_DIV2: begin
          rem <= next_rem;
          quo <= next_quo;
          cnt <= cnt - CW'(1);
          if (cnt == CW'(1)) begin
            kelvin       <= k_new;
            out_of_range <= (k_new < LO) || (k_new > HI);
            done         <= 1'b1;
            st           <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/temp_kelvin_calc_chk.sv
module temp_kelvin_calc_chk #(
  parameter int W     = 48,
  parameter int T_MIN = 263,
  parameter int T_MAX = 410
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                done,
  input logic                div_err,
  input logic                out_of_range,
  input logic signed [W-1:0] kelvin
);
  localparam logic signed [W-1:0] LO = W'(T_MIN);
  localparam logic signed [W-1:0] HI = W'(T_MAX);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R4
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n) div_err |-> done); // R7
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) div_err |-> $stable(kelvin)); // R7
  AST_RANGE_FLAG: assert property (@(posedge clk) disable iff (!rst_n) out_of_range == ((kelvin < LO) || (kelvin > HI))); // R8
  AST_TEMP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(kelvin)); // R10
endmodule

bind temp_kelvin_calc temp_kelvin_calc_chk #(.W(W), .T_MIN(T_MIN), .T_MAX(T_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .div_err(div_err),
  .out_of_range(out_of_range), .kelvin(kelvin)
);

// File: tb/sim_temp_kelvin_calc.sv
module sim_temp_kelvin_calc;
  localparam int W = 48;
  localparam int LAT = 2 * W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_load = 1'b0, live_we = 1'b0, start = 1'b0;
  logic signed [31:0] cal_a = '0, cal_b = '0, cal_c = '0;
  logic [22:0] live_raw = '0;
  logic busy, done, div_err, out_of_range;
  logic signed [W-1:0] kelvin, celsius;

  int checks = 0;
  int errors = 0;
  longint prev_k = 0;
  longint cur_a = 0, cur_b = 0, cur_c = 0;

  always #10 clk = ~clk;

  temp_kelvin_calc u0 (
    .clk(clk), .rst_n(rst_n), .cal_load(cal_load), .cal_a(cal_a), .cal_b(cal_b),
    .cal_c(cal_c), .live_we(live_we), .live_raw(live_raw), .start(start),
    .busy(busy), .done(done), .div_err(div_err), .out_of_range(out_of_range),
    .kelvin(kelvin), .celsius(celsius)
  );

  function automatic longint sx23(input logic [22:0] v);
    return v[22] ? longint'(v) - (longint'(1) <<< 23) : longint'(v);
  endfunction

  function automatic longint exp_k(input longint a, b, c, input longint l);
    longint t;
    if (c == a) return prev_k;
    t = (longint'(25123) * (l - b)) / (c - a);
    t = t / 100;
    return t + 8;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic run(input bit load_cal, input longint a, b, c, input logic [22:0] l,
                     input int restart_at, input int poke_at, input string req);
    int n;
    bit zero;
    longint e;
    @(negedge clk);
    if (load_cal) begin
      cal_a = a[31:0]; cal_b = b[31:0]; cal_c = c[31:0];
      cur_a = a; cur_b = b; cur_c = c;
    end else begin
      cal_a = $urandom(); cal_b = $urandom(); cal_c = $urandom();
    end
    cal_load = load_cal;
    live_raw = l;
    live_we  = 1'b1;
    @(negedge clk);
    cal_load = 1'b0;
    live_we  = 1'b0;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    zero = (cur_a == cur_c);
    e = exp_k(cur_a, cur_b, cur_c, sx23(l));
    chk(busy == !zero, "R4 busy after start", longint'(busy), longint'(!zero));
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
      start = (n == restart_at);
      if (n == poke_at) begin
        live_raw = ~l;
        live_we  = 1'b1;
      end else live_we = 1'b0;
    end
    start = 1'b0;
    live_we = 1'b0;
    if (zero) begin
      chk(n == 0, "R7 error latency", n, 0);
      chk(div_err == 1'b1, "R7 error flag", longint'(div_err), 1);
      chk(longint'(kelvin) == prev_k, "R7 kelvin held", longint'(kelvin), prev_k);
    end else begin
      chk(n == LAT, {req, " R4 latency"}, n, LAT);
      chk(longint'(kelvin) == e, {req, " R2 kelvin"}, longint'(kelvin), e);
      chk(div_err == 1'b0, "R7 no error", longint'(div_err), 0);
      chk(!busy, "R4 busy low at done", longint'(busy), 0);
    end
    chk(longint'(celsius) == e - 273, "R9 celsius", longint'(celsius), e - 273);
    chk(out_of_range == (e < 263 || e > 410), "R8 range flag", longint'(out_of_range),
        longint'(e < 263 || e > 410));
    prev_k = e;
    @(negedge clk);
    chk(!done, "R4 done single cycle", longint'(done), 0);
    if (restart_at > 0) begin
      for (int i = 0; i < LAT + 10; i++) begin
        @(negedge clk);
        if (done || busy) begin
          chk(0, "R5 restart ignored", longint'(done), 0);
          break;
        end
      end
      chk(longint'(kelvin) == e, "R5 result unchanged", longint'(kelvin), e);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    chk(!busy && !done && !div_err, "R1 control idle in reset", longint'({busy, done, div_err}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(kelvin == 0, "R1 kelvin", longint'(kelvin), 0);
    chk(celsius == -273, "R1 celsius", longint'(celsius), -273);
    chk(out_of_range == 1'b1, "R1 range flag", longint'(out_of_range), 1);
    chk(!busy && !done, "R1 idle", longint'({busy, done}), 0);

    run(1, 0, 0, 25123, 23'd25500, -1, -1, "R8 low edge");
    run(1, 0, 0, 25123, 23'd25400, -1, -1, "R8 below");
    run(1, 0, 0, 25123, 23'd40200, -1, -1, "R8 high edge");
    run(1, 0, 0, 25123, 23'd40300, -1, -1, "R8 above");
    run(1, 0, 0, 25123, -23'sd150, -1, -1, "R2 truncation");
    run(1, 0, 0, 25123, 23'h7FFFFF, -1, -1, "R3 minus one");
    run(1, 0, 0, 25123, 23'h400000, -1, -1, "R3 most negative");
    run(1, 1000, 2000, 4000, 23'd38000, -1, -1, "R2 typical");
    run(1, 5000, -700, 2000, 23'd12345, -1, -1, "R2 negative divisor");
    run(1, 777, 10, 777, 23'd5000, -1, -1, "R7 zero divisor");
    run(1, 1000, 2000, 4000, 23'd38000, 10, 20, "R5 R6 restart and live write");
    run(0, 0, 0, 0, 23'd31000, -1, -1, "R11 calibration kept");

    for (int k = 0; k < 40; k++) begin
      longint a, b, c;
      a = longint'($signed($urandom()));
      b = longint'($signed($urandom()));
      c = (k % 2 == 0) ? a + longint'($urandom_range(1, 60000)) : longint'($signed($urandom()));
      if (c > 64'sd2147483647) c = a - 1;
      run(1, a, b, c, 23'($urandom()), -1, -1, "R2 random");
    end
    summary();
  end
endmodule